// File: doc/BRIEF.md
# Two-Phase Fetch/Execute Control Unit

This block is the control core and register storage of a small processor that has no separate sequencer. Each instruction is one 16-bit horizontal control word whose bits drive the datapath directly. Every instruction occupies two clocks. In the first clock a fixed fetch word sits in the instruction register. That word places the program-counter register on the memory address and on ALU operand A, and writes the external ALU's result (A+1) back into the same register. The word read from memory is captured in the instruction register instead of the register file. In the second clock the captured word drives the datapath, and the instruction register is then refilled with the fetch word.

The register file holds eight registers. In one cycle it offers three ports. Port A is write only. Port B is read only and feeds ALU operand B and the store data. Port C is read, and optionally written, and feeds the memory address and ALU operand A. Loads, stores, and post-increment or post-decrement of the address register are built from these ports and the ALU function field, which the external ALU decodes from `ir_out`.

A single interrupt flag redirects the fetch from register 7 to register 6. The flag is set while interrupts are enabled, and a dedicated decoded control word clears it.

Control word fields, most significant first:
- [15:13] ALU function
- [12] store (1) / load (0)
- [11] memory access
- [10] write port C
- [9] write port A
- [8:6] A index
- [5:3] B index
- [2:0] C index

Top module: `ftx_ctrl_unit`

## Requirements
- R1: While `rst` is high, and on the cycle after it falls, all registers read zero, `exec_phase` is 0, `ir_out` is 16'h2C07, the interrupt flag is clear, and interrupts are disabled.
- R2: `exec_phase` alternates 0 (fetch) and 1 (execute) on every clock after reset.
- R3: In a fetch cycle with the interrupt flag clear, `mem_addr` and `alu_a` equal register 7. `alu_b` equals register 0, and `mem_rd` is 1 with `mem_wr` 0. Register 7 takes `alu_result` at the clock edge.
- R4: At the end of fetch, `mem_rdata[15:0]` is loaded into the instruction register, so it appears on `ir_out` during execute. The register file is not written from memory in a fetch.
- R5: In execute, `mem_addr` and `alu_a` show the register at the C index, and `alu_b` and `mem_wdata` show the register at the B index. With bit 9 set and no load, the A-index register takes `alu_result`.
- R6: In execute with bit 11 set, bit 12 = 0 gives a read (`mem_rd`=1), and with bit 9 set `mem_rdata` is written to the A-index register. Bit 12 = 1 gives a write (`mem_wr`=1) of the B-index register. With bit 10 set, the C-index register takes `alu_result`; this gives post-increment and post-decrement.
- R7: When ports A and C write the same register in one cycle, the port C value is kept.
- R8: A control word with bits 11, 10 and 9 all clear is decoded by its B index: 1 clears the interrupt flag, 2 enables interrupts, and 3 disables them. All other values do nothing.
- R9: A clock edge with `irq` high while interrupts are enabled sets the flag. While the flag is set, fetch uses register 6 in place of register 7, both as the address and as the incremented register.
- R10: While interrupts are disabled, `irq` cannot set the flag, and fetches continue from register 7.
- R11: The flag is cleared only by the clear word in execute. A set in the same cycle takes priority over the clear.
- R12: At the end of every execute cycle the instruction register is reloaded with 16'h2C07.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq | input | 1 | Interrupt request level |
| mem_addr | output | 16 | Memory address (port C read) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Store data (port B read) |
| mem_rdata | input | 16 | Memory read data |
| alu_a | output | 16 | ALU operand A (port C read) |
| alu_b | output | 16 | ALU operand B (port B read) |
| alu_result | input | 16 | ALU result, combinational from operands and `ir_out[15:13]` |
| ir_out | output | 16 | Instruction register contents |
| exec_phase | output | 1 | 0 in fetch, 1 in execute |

## Verification
The assertions assume the memory returns `mem_rdata` and the ALU returns `alu_result` within the same cycle. They also assume `irq` changes only between clock edges. The bench meets these assumptions with combinational memory and ALU models, and it drives `irq` on the falling edge. It places the interrupt service words and the data words in regions the main program never fetches. Every interrupt entry therefore lands on a known service word, and a return from interrupt shows up as a fetch address below 16'h0080.

// File: rtl/ftx_pkg.sv
package ftx_pkg;
   localparam int FLD_W  = 3;
   localparam int UI_W   = 16;

   typedef struct packed {
      logic [2:0] fn;
      logic       st;
      logic       mem;
      logic       wc;
      logic       wa;
      logic [2:0] asel;
      logic [2:0] bsel;
      logic [2:0] csel;
   } uinst_t;

   localparam logic [2:0] AUX_NONE = 3'd0;
   localparam logic [2:0] AUX_CLR  = 3'd1;
   localparam logic [2:0] AUX_EI   = 3'd2;
   localparam logic [2:0] AUX_DI   = 3'd3;

   typedef enum logic {PH_FETCH = 1'b0, PH_EXEC = 1'b1} phase_t;

   function automatic logic [UI_W-1:0] make_fetch_word(input logic [2:0] fn,
                                                       input logic [2:0] pc);
      uinst_t u;
      u.fn   = fn;
      u.st   = 1'b0;
      u.mem  = 1'b1;
      u.wc   = 1'b1;
      u.wa   = 1'b0;
      u.asel = 3'd0;
      u.bsel = 3'd0;
      u.csel = pc;
      return u;
   endfunction
endpackage

// File: rtl/ftx_regfile.sv
module ftx_regfile #(
   parameter int W      = 16,
   parameter int N      = 8,
   parameter bit C_WINS = 1'b1,
   localparam int IDX_W = $clog2(N)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             a_we,
   input  logic [IDX_W-1:0] a_idx,
   input  logic [W-1:0]     a_data,
   input  logic [IDX_W-1:0] b_idx,
   output logic [W-1:0]     b_data,
   input  logic             c_we,
   input  logic [IDX_W-1:0] c_idx,
   input  logic [W-1:0]     c_data,
   output logic [W-1:0]     c_rdata
);
   logic [W-1:0] rf [N];

   for (genvar i = 0; i < N; i++) begin : g_reg
      logic [W-1:0] q;
      logic         hit_a;
      logic         hit_c;
      assign hit_a = a_we && (a_idx == IDX_W'(i));
      assign hit_c = c_we && (c_idx == IDX_W'(i));
      if (C_WINS) begin : g_cfirst
         always_ff @(posedge clk) begin
            if (rst)        q <= '0;
            else if (hit_c) q <= c_data;
            else if (hit_a) q <= a_data;
         end
      end else begin : g_afirst
         always_ff @(posedge clk) begin
            if (rst)        q <= '0;
            else if (hit_a) q <= a_data;
            else if (hit_c) q <= c_data;
         end
      end
      assign rf[i] = q;
   end

   assign b_data  = rf[b_idx];
   assign c_rdata = rf[c_idx];
endmodule

// File: rtl/ftx_sequencer.sv
module ftx_sequencer import ftx_pkg::*; #(
   parameter logic [UI_W-1:0] FETCH_WORD = 16'h2C07
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [UI_W-1:0] fetched,
   output phase_t          phase,
   output logic [UI_W-1:0] ir
);
   always_ff @(posedge clk) begin
      if (rst) begin
         phase <= PH_FETCH;
         ir    <= FETCH_WORD;
      end else if (phase == PH_FETCH) begin
         phase <= PH_EXEC;
         ir    <= fetched;
      end else begin
         phase <= PH_FETCH;
         ir    <= FETCH_WORD;
      end
   end
endmodule

// File: rtl/ftx_irq_ctrl.sv
module ftx_irq_ctrl #(
   parameter bit SET_BEATS_CLEAR = 1'b1,
   parameter bit IEN_AT_RESET    = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic irq,
   input  logic op_clr,
   input  logic op_ei,
   input  logic op_di,
   output logic flag,
   output logic ien
);
   logic set_req;
   assign set_req = irq && ien;

   always_ff @(posedge clk) begin
      if (rst)        ien <= IEN_AT_RESET;
      else if (op_di) ien <= 1'b0;
      else if (op_ei) ien <= 1'b1;
   end

   if (SET_BEATS_CLEAR) begin : g_set_first
      always_ff @(posedge clk) begin
         if (rst)          flag <= 1'b0;
         else if (set_req) flag <= 1'b1;
         else if (op_clr)  flag <= 1'b0;
      end
   end else begin : g_clr_first
      always_ff @(posedge clk) begin
         if (rst)          flag <= 1'b0;
         else if (op_clr)  flag <= 1'b0;
         else if (set_req) flag <= 1'b1;
      end
   end
endmodule

// File: rtl/ftx_decode.sv
module ftx_decode import ftx_pkg::*; #(
   parameter int ISR_IDX = 6
) (
   input  phase_t           phase,
   input  logic [UI_W-1:0]  ir,
   input  logic             flag,
   output logic [FLD_W-1:0] a_idx,
   output logic [FLD_W-1:0] b_idx,
   output logic [FLD_W-1:0] c_idx,
   output logic             a_we,
   output logic             c_we,
   output logic             a_from_mem,
   output logic             mem_rd,
   output logic             mem_wr,
   output logic             op_clr,
   output logic             op_ei,
   output logic             op_di
);
   uinst_t ui;
   logic   exec;
   logic   quiet;

   always_comb begin
      ui     = uinst_t'(ir);
      exec   = (phase == PH_EXEC);
      quiet  = !ui.mem && !ui.wa && !ui.wc;
      a_idx  = ui.asel;
      b_idx  = ui.bsel;
      c_idx  = (!exec && flag) ? FLD_W'(ISR_IDX) : ui.csel;
      a_we   = exec && ui.wa;
      c_we   = ui.wc;
      mem_rd = ui.mem && !ui.st;
      mem_wr = exec && ui.mem && ui.st;
      a_from_mem = mem_rd;
      op_clr = exec && quiet && (ui.bsel == AUX_CLR);
      op_ei  = exec && quiet && (ui.bsel == AUX_EI);
      op_di  = exec && quiet && (ui.bsel == AUX_DI);
   end
endmodule

// File: rtl/ftx_ctrl_unit.sv
module ftx_ctrl_unit import ftx_pkg::*; #(
   parameter int         REG_W           = 16,
   parameter int         NREGS           = 8,
   parameter int         PC_IDX          = 7,
   parameter int         ISR_IDX         = 6,
   parameter logic [2:0] FETCH_FN        = 3'd1,
   parameter bit         C_PORT_WINS     = 1'b1,
   parameter bit         SET_BEATS_CLEAR = 1'b1,
   parameter bit         IEN_AT_RESET    = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             irq,
   output logic [REG_W-1:0] mem_addr,
   output logic             mem_rd,
   output logic             mem_wr,
   output logic [REG_W-1:0] mem_wdata,
   input  logic [REG_W-1:0] mem_rdata,
   output logic [REG_W-1:0] alu_a,
   output logic [REG_W-1:0] alu_b,
   input  logic [REG_W-1:0] alu_result,
   output logic [UI_W-1:0]  ir_out,
   output logic             exec_phase
);
   localparam logic [UI_W-1:0] FETCH_WORD = make_fetch_word(FETCH_FN, FLD_W'(PC_IDX));

   if (REG_W < UI_W) begin : g_bad_width
      $error("REG_W must hold a full control word");
   end
   if (NREGS != (1 << FLD_W)) begin : g_bad_depth
      $error("NREGS must match the 3-bit register index fields");
   end
   if (PC_IDX == ISR_IDX || PC_IDX >= NREGS || ISR_IDX >= NREGS) begin : g_bad_idx
      $error("PC_IDX and ISR_IDX must be distinct valid registers");
   end

   phase_t           phase;
   logic [UI_W-1:0]  ir;
   logic [FLD_W-1:0] a_idx, b_idx, c_idx;
   logic             a_we, c_we, a_from_mem;
   logic             clr_op, ei_op, di_op;
   logic             irq_flag, int_en;
   logic [REG_W-1:0] b_data, c_rdata, a_data;

   ftx_sequencer #(.FETCH_WORD(FETCH_WORD)) u_seq (
      .clk     (clk),
      .rst     (rst),
      .fetched (mem_rdata[UI_W-1:0]),
      .phase   (phase),
      .ir      (ir)
   );

   ftx_decode #(.ISR_IDX(ISR_IDX)) u_dec (
      .phase      (phase),
      .ir         (ir),
      .flag       (irq_flag),
      .a_idx      (a_idx),
      .b_idx      (b_idx),
      .c_idx      (c_idx),
      .a_we       (a_we),
      .c_we       (c_we),
      .a_from_mem (a_from_mem),
      .mem_rd     (mem_rd),
      .mem_wr     (mem_wr),
      .op_clr     (clr_op),
      .op_ei      (ei_op),
      .op_di      (di_op)
   );

   ftx_irq_ctrl #(
      .SET_BEATS_CLEAR (SET_BEATS_CLEAR),
      .IEN_AT_RESET    (IEN_AT_RESET)
   ) u_irq (
      .clk    (clk),
      .rst    (rst),
      .irq    (irq),
      .op_clr (clr_op),
      .op_ei  (ei_op),
      .op_di  (di_op),
      .flag   (irq_flag),
      .ien    (int_en)
   );

   assign a_data = a_from_mem ? mem_rdata : alu_result;

   ftx_regfile #(.W(REG_W), .N(NREGS), .C_WINS(C_PORT_WINS)) u_rf (
      .clk     (clk),
      .rst     (rst),
      .a_we    (a_we),
      .a_idx   (a_idx),
      .a_data  (a_data),
      .b_idx   (b_idx),
      .b_data  (b_data),
      .c_we    (c_we),
      .c_idx   (c_idx),
      .c_data  (alu_result),
      .c_rdata (c_rdata)
   );

   assign mem_addr   = c_rdata;
   assign alu_a      = c_rdata;
   assign alu_b      = b_data;
   assign mem_wdata  = b_data;
   assign ir_out     = ir;
   assign exec_phase = (phase == PH_EXEC);
endmodule

// File: rtl/ftx_ctrl_unit_chk.sv
module ftx_ctrl_unit_chk #(
   parameter logic [15:0] FETCH_WORD = 16'h2C07
) (
   input logic        clk,
   input logic        rst,
   input logic        irq,
   input logic        exec_phase,
   input logic [15:0] ir_out,
   input logic [15:0] mem_rdata,
   input logic        mem_rd,
   input logic        mem_wr,
   input logic        int_en,
   input logic        irq_flag,
   input logic        clr_op
);
   assert_exec_follows_R2: assert property (@(posedge clk) disable iff (rst)
      !exec_phase |=> exec_phase);
   assert_fetch_follows_R2: assert property (@(posedge clk) disable iff (rst)
      exec_phase |=> !exec_phase);
   assert_fetch_reads_R3: assert property (@(posedge clk) disable iff (rst)
      !exec_phase |-> (mem_rd && !mem_wr));
   assert_ir_capture_R4: assert property (@(posedge clk) disable iff (rst)
      exec_phase |-> (ir_out == $past(mem_rdata)));
   assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (rst)
      !(mem_rd && mem_wr));
   assert_flag_set_R9: assert property (@(posedge clk) disable iff (rst)
      (irq && int_en) |=> irq_flag);
   assert_flag_blocked_R10: assert property (@(posedge clk) disable iff (rst)
      (!int_en && !irq_flag) |=> !irq_flag);
   assert_flag_hold_R11: assert property (@(posedge clk) disable iff (rst)
      (irq_flag && !clr_op) |=> irq_flag);
   assert_ir_reload_R12: assert property (@(posedge clk) disable iff (rst)
      exec_phase |=> (ir_out == FETCH_WORD));
endmodule

bind ftx_ctrl_unit ftx_ctrl_unit_chk #(.FETCH_WORD(FETCH_WORD)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .irq        (irq),
   .exec_phase (exec_phase),
   .ir_out     (ir_out),
   .mem_rdata  (mem_rdata[15:0]),
   .mem_rd     (mem_rd),
   .mem_wr     (mem_wr),
   .int_en     (int_en),
   .irq_flag   (irq_flag),
   .clr_op     (clr_op)
);

// File: tb/ftx_ctrl_unit_bench.sv
module ftx_ctrl_unit_bench;
   localparam logic [15:0] FETCH = 16'h2C07;
   localparam int NCYC = 140;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        irq = 1'b0;
   logic [15:0] mem_addr, mem_wdata, mem_rdata, alu_a, alu_b, alu_result, ir_out;
   logic        mem_rd, mem_wr, exec_phase;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [15:0] env_mem [256];
   logic [15:0] mref    [256];
   logic [15:0] m_regs  [8];
   logic        m_exec, m_flag, m_ien;
   logic [15:0] m_ir;
   int          isr_fetches = 0;
   bit          blocked_pending = 1'b0;
   bit          ret_pending = 1'b0;
   bit          stay_pending = 1'b0;

   always #10 clk = ~clk;

   function automatic logic [15:0] alu_f(input logic [2:0] f, input logic [15:0] a, input logic [15:0] b);
      case (f)
         3'd0: return a;
         3'd1: return a + 16'd1;
         3'd2: return a - 16'd1;
         3'd3: return b;
         3'd4: return a + b;
         3'd5: return a - b;
         3'd6: return a & b;
         default: return a ^ b;
      endcase
   endfunction

   function automatic logic [15:0] mk(input int fn, input int st, input int mm, input int wc,
                                      input int wa, input int as, input int bs, input int cs);
      return {fn[2:0], st[0], mm[0], wc[0], wa[0], as[2:0], bs[2:0], cs[2:0]};
   endfunction

   assign mem_rdata  = env_mem[mem_addr[7:0]];
   assign alu_result = alu_f(ir_out[15:13], alu_a, alu_b);

   always @(posedge clk) begin
      if (!rst && mem_wr) env_mem[mem_addr[7:0]] <= mem_wdata;
   end

   ftx_ctrl_unit u_ftx_ctrl_unit (
      .clk        (clk),
      .rst        (rst),
      .irq        (irq),
      .mem_addr   (mem_addr),
      .mem_rd     (mem_rd),
      .mem_wr     (mem_wr),
      .mem_wdata  (mem_wdata),
      .mem_rdata  (mem_rdata),
      .alu_a      (alu_a),
      .alu_b      (alu_b),
      .alu_result (alu_result),
      .ir_out     (ir_out),
      .exec_phase (exec_phase)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic put(input int a, input logic [15:0] w);
      env_mem[a] = w;
      mref[a]    = w;
   endtask

   task automatic load_prog();
      for (int i = 0; i < 256; i++) put(i, 16'h0000);
      put(0,  mk(1,0,1,1,1,1,0,7)); put(1, 16'h1234);   // LDI R1
      put(2,  mk(1,0,1,1,1,2,0,7)); put(3, 16'h0040);   // LDI R2
      put(4,  mk(4,0,0,0,1,3,2,1));                     // R3 = R1 + R2
      put(5,  mk(2,1,1,1,0,0,3,2));                     // store R3 at [R2], R2--
      put(6,  mk(1,0,1,1,1,5,0,7)); put(7, 16'h0040);   // LDI R5
      put(8,  mk(0,0,1,0,1,4,0,5));                     // R4 = [R5]
      put(9,  mk(0,0,0,0,1,0,0,4));                     // R0 = R4
      put(10, mk(1,0,1,1,1,5,0,5));                     // R5 = [R5], R5++ (port clash)
      put(11, mk(0,0,0,0,1,0,0,5));                     // R0 = R5
      put(12, mk(1,0,1,1,1,6,0,7)); put(13, 16'h0080);  // LDI R6
      put(14, mk(0,0,0,0,0,0,2,0));                     // enable
      put(17, mk(0,0,0,0,0,0,3,0));                     // disable
      put(22, mk(0,0,0,0,0,0,2,0));                     // enable
      put(27, mk(2,0,0,1,0,0,0,7));                     // R7 = R7 - 1 : self loop
      put(128, mk(0,0,0,0,1,0,0,1));                    // service: R0 = R1
      for (int i = 129; i < 256; i++) put(i, mk(0,0,0,0,0,0,1,0)); // clear flag
   endtask

   function automatic logic irq_at(input int c);
      return (c == 3) || (c == 23) || (c >= 33 && c <= 37) || (c >= 50 && c <= 55);
   endfunction

   task automatic compare_and_step();
      logic [15:0] w;
      logic [2:0]  fn, as, bs, cs;
      logic        st, mm, wc, wa, quiet, set_req, clr;
      logic [15:0] ra, rb, res, ld;
      string       tg;
      w  = m_exec ? m_ir : FETCH;
      fn = w[15:13]; st = w[12]; mm = w[11]; wc = w[10]; wa = w[9];
      as = w[8:6]; bs = w[5:3]; cs = w[2:0];
      if (!m_exec) cs = m_flag ? 3'd6 : 3'd7;
      ra = m_regs[cs];
      rb = m_regs[bs];
      tg = !m_exec ? (m_flag ? "R9" : "R3") : (mm ? "R6" : "R5");

      chk("R2 phase", {15'd0, exec_phase}, {15'd0, m_exec});
      chk(m_exec ? "R4 ir" : "R12 ir", ir_out, w);
      chk({tg, " addr"}, mem_addr, ra);
      chk({tg, " alu_a"}, alu_a, ra);
      chk({tg, " alu_b"}, alu_b, rb);
      chk({tg, " wdata"}, mem_wdata, rb);
      chk({tg, " rd"}, {15'd0, mem_rd}, {15'd0, mm && !st});
      chk({tg, " wr"}, {15'd0, mem_wr}, {15'd0, m_exec && mm && st});

      // directed expectations
      if (m_exec && w == mk(0,0,0,0,1,0,0,5)) chk("R7 port C kept", alu_a, 16'h0041);
      if (!m_exec && blocked_pending) begin
         chk("R10 fetch stays main", {15'd0, mem_addr < 16'h0080}, 16'd1);
         blocked_pending = 1'b0;
      end
      if (!m_exec && ret_pending) begin
         chk("R11 return after clear", {15'd0, mem_addr < 16'h0080}, 16'd1);
         ret_pending = 1'b0;
      end
      if (!m_exec && stay_pending) begin
         chk("R11 set beats clear", {15'd0, mem_addr >= 16'h0080}, 16'd1);
         stay_pending = 1'b0;
      end
      if (!m_exec && m_flag) isr_fetches++;

      // model next state
      quiet   = !mm && !wa && !wc;
      clr     = m_exec && quiet && bs == 3'd1;
      set_req = irq && m_ien;
      if (irq && !m_ien && !m_flag) blocked_pending = 1'b1;
      if (clr && !set_req) ret_pending = 1'b1;
      if (clr && set_req) stay_pending = 1'b1;
      if (!m_exec) begin
         m_ir = mref[ra[7:0]];
         m_regs[cs] = alu_f(fn, ra, rb);
      end else begin
         res = alu_f(fn, ra, rb);
         ld  = mref[ra[7:0]];
         if (mm && st) mref[ra[7:0]] = rb;
         if (wa) m_regs[as] = (mm && !st) ? ld : res;
         if (wc) m_regs[cs] = res;
         if (quiet && bs == 3'd3) m_ien = 1'b0;
         else if (quiet && bs == 3'd2) m_ien = 1'b1;
      end
      if (set_req) m_flag = 1'b1;
      else if (clr) m_flag = 1'b0;
      m_exec = !m_exec;
   endtask

   initial begin
      load_prog();
      for (int i = 0; i < 8; i++) m_regs[i] = 16'h0000;
      m_exec = 1'b0; m_flag = 1'b0; m_ien = 1'b0; m_ir = FETCH;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state visible at the ports
      chk("R1 phase", {15'd0, exec_phase}, 16'd0);
      chk("R1 ir", ir_out, FETCH);
      chk("R1 addr", mem_addr, 16'h0000);
      chk("R1 alu_b", alu_b, 16'h0000);
      rst = 1'b0;
      for (int cyc = 0; cyc < NCYC; cyc++) begin
         if (cyc > 0) @(negedge clk);
         irq = irq_at(cyc);
         #1;
         compare_and_step();
      end
      chk("R8 service entries", {15'd0, isr_fetches > 2}, 16'd1);
      chk("R6 stored word", env_mem[16'h40], 16'h1274);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(20 * 5000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule